// File: doc/BRIEF.md
# MII Carrier-Sense and Collision Generator

This block produces the two status outputs that an Ethernet PHY presents to its MAC on the MII: carrier sense and collision. It works from flags raised by the rest of the PHY. These are transmit activity, receive activity, valid receive data, link state and a strobe for each received line bit. It also takes a single-cycle bit-time enable, a speed select, a duplex select, a heartbeat enable and an end-of-packet pulse. All timing is counted in bit-time enable pulses, so the same logic serves both line rates.

Collision reporting depends on which channel was busy first. At 10 Mb/s, when a transmission meets incoming data, the collision is filtered for a number of bit times before it is reported, to reject line noise. A collision that begins while reception is already under way, and any collision at 100 Mb/s, is reported at once. At 10 Mb/s in half duplex, a heartbeat (signal quality) pulse can also be placed on the collision output after each transmitted packet. Carrier sense is qualified differently for each speed and each duplex mode, and it is dropped at the end of the packet.

Top module: `mii_crs_col_gen`

## Requirements
- R1: A collision condition exists when duplex select is half (full_dup=0) and tx_act and rx_act are both high in a cycle. At 100 Mb/s (spd_100=1) the condition raises col in the following cycle.
- R2: At 10 Mb/s (spd_100=0), a collision condition whose first cycle finds rx_act low in the previous cycle (a transmit-first or simultaneous start) raises col only in the cycle after the 7th bit_en pulse. The count includes the first cycle of the condition and runs only while the condition holds without a break.
- R3: At 10 Mb/s, a collision condition that begins while rx_act was already high in the previous cycle raises col in the following cycle.
- R4: col from a collision stays high while the condition lasts. It falls in the cycle after the condition ends. A later collision starts its bit count again from zero.
- R5: Heartbeat applies only at 10 Mb/s, in half duplex, with hb_en=1. A cycle in which tx_act falls (high before, low now) starts a wait of 10 bit_en pulses. col is then high from the cycle after the 10th waiting pulse until the cycle after a further 10th pulse. Rising tx_act, a change to 100 Mb/s, full duplex or hb_en=0 cancels a pending or running pulse.
- R6: At 10 Mb/s, a cycle with rx_act and rx_valid both high sets the receive carrier. crs is high from the next cycle until the carrier is cleared.
- R7: At 100 Mb/s with link_ok=1, a received zero is a bit_stb cycle with bit_val=0. A zero counts only if the previous strobed bit was not zero. The second counted zero sets the receive carrier, so crs is high from the next cycle. Two adjacent zeros alone do not.
- R8: In half duplex, tx_act raises crs in the next cycle. In full duplex, transmit activity alone leaves crs low.
- R9: An eop pulse clears the receive carrier and the zero count, and so does link_ok=0 at 100 Mb/s. In the next cycle crs is low unless a half-duplex transmission holds it.
- R10: In full duplex, col is low in every cycle after the first cycle with full_dup=1, and this includes the heartbeat.
- R11: While rst_n is low, and in the first cycle after its release, crs and col are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_act | input | 1 | Transmit channel active |
| rx_act | input | 1 | Receive channel active |
| rx_valid | input | 1 | Valid receive data detected (10 Mb/s) |
| link_ok | input | 1 | Link valid (100 Mb/s) |
| bit_stb | input | 1 | A received line bit is present in this cycle |
| bit_val | input | 1 | Value of the strobed line bit |
| bit_en | input | 1 | One-cycle pulse per bit time |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| hb_en | input | 1 | Heartbeat pulse enable |
| eop | input | 1 | End-of-packet pulse |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision / heartbeat |

## Verification
On every cycle the assertions check these relations: the silence of col in full duplex, the one-cycle response to a collision at 100 Mb/s and to one that starts during reception at 10 Mb/s, the drop of col when the condition ends, carrier sense driven by half-duplex transmit, its clearing by end of packet, and the absence of heartbeat at 100 Mb/s. Some behaviour needs a count of bit-time pulses over a history, and only the bench scenarios can show it: the seven-bit filter and its restart after a break, the gap and width of the heartbeat, and the zero-pair rule at 100 Mb/s. For these the bench keeps a cycle model and compares both outputs each cycle, with directed cases and random traffic over all speed and duplex settings.

// File: rtl/mii_cc_pkg.sv
package mii_cc_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mii_coll_detect.sv
module mii_coll_detect #(
  parameter int unsigned DELAY_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic rx_act,
  input  logic full_dup,
  input  logic spd_100,
  input  logic bit_en,
  output logic coll_col
);

  localparam int unsigned CW = $clog2(DELAY_BITS + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(DELAY_BITS);

  logic          coll_now;
  logic          coll_start;
  logic          coll_prev_q;
  logic          rx_prev_q;
  logic          slow_mode_q, slow_mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          col_q, col_d;

  assign coll_now   = !full_dup && tx_act && rx_act;
  assign coll_start = coll_now && !coll_prev_q;

  always_comb begin
    slow_mode_d = slow_mode_q;
    if (coll_start) begin
      slow_mode_d = !spd_100 && !rx_prev_q;
    end
    cnt_d = cnt_q;
    if (!coll_now) begin
      cnt_d = '0;
    end else if (bit_en && (cnt_q != CNT_TOP)) begin
      cnt_d = cnt_q + 1'b1;
    end
    col_d = coll_now && (!slow_mode_d || (cnt_d == CNT_TOP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_prev_q <= 1'b0;
      rx_prev_q   <= 1'b0;
      slow_mode_q <= 1'b0;
      cnt_q       <= '0;
      col_q       <= 1'b0;
    end else begin
      coll_prev_q <= coll_now;
      rx_prev_q   <= rx_act;
      slow_mode_q <= slow_mode_d;
      cnt_q       <= cnt_d;
      col_q       <= col_d;
    end
  end

  assign coll_col = col_q;

endmodule

// File: rtl/mii_sqe_timer.sv
module mii_sqe_timer
  import mii_cc_pkg::*;
#(
  parameter int unsigned GAP_BITS = 10,
  parameter int unsigned LEN_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic full_dup,
  input  logic spd_100,
  input  logic hb_en,
  input  logic bit_en,
  output logic hb_pulse
);

  localparam int unsigned MAXB = max2(GAP_BITS, LEN_BITS);
  localparam int unsigned CW   = $clog2(MAXB + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_BITS - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(LEN_BITS - 1);

  hb_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tx_prev_q;
  logic          allowed;
  logic          tx_end;

  assign allowed = hb_en && !spd_100 && !full_dup;
  assign tx_end  = tx_prev_q && !tx_act;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      HB_IDLE: begin
        if (tx_end && allowed) begin
          st_d  = HB_WAIT;
          cnt_d = '0;
        end
      end
      HB_WAIT: begin
        if (!allowed || tx_act) begin
          st_d  = HB_IDLE;
          cnt_d = '0;
        end else if (bit_en) begin
          if (cnt_q == GAP_LAST) begin
            st_d  = HB_PULSE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      HB_PULSE: begin
        if (!allowed || tx_act) begin
          st_d  = HB_IDLE;
          cnt_d = '0;
        end else if (bit_en) begin
          if (cnt_q == LEN_LAST) begin
            st_d  = HB_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        st_d  = HB_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= HB_IDLE;
      cnt_q     <= '0;
      tx_prev_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      tx_prev_q <= tx_act;
    end
  end

  assign hb_pulse = (st_q == HB_PULSE);

endmodule

// File: rtl/mii_crs_qual.sv
module mii_crs_qual #(
  parameter int unsigned ZEROS_NEEDED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_act,
  input  logic rx_valid,
  input  logic link_ok,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic spd_100,
  input  logic full_dup,
  input  logic tx_act,
  input  logic eop,
  output logic crs
);

  localparam int unsigned ZW = $clog2(ZEROS_NEEDED + 1);
  localparam logic [ZW-1:0] ZTOP = ZW'(ZEROS_NEEDED);

  logic          carr_q, carr_d;
  logic [ZW-1:0] zcnt_q, zcnt_d;
  logic          last0_q, last0_d;
  logic          crs_q, crs_d;
  logic          clear;
  logic          zero_evt;

  assign clear    = eop || (spd_100 && !link_ok);
  assign zero_evt = bit_stb && !bit_val && !last0_q;

  always_comb begin
    carr_d  = carr_q;
    zcnt_d  = zcnt_q;
    last0_d = last0_q;
    if (clear) begin
      carr_d  = 1'b0;
      zcnt_d  = '0;
      last0_d = 1'b0;
    end else if (!spd_100) begin
      zcnt_d  = '0;
      last0_d = 1'b0;
      if (rx_act && rx_valid) begin
        carr_d = 1'b1;
      end
    end else if (bit_stb) begin
      last0_d = !bit_val;
      if (zero_evt) begin
        zcnt_d = (zcnt_q == ZTOP) ? ZTOP : zcnt_q + 1'b1;
        if (zcnt_d == ZTOP) begin
          carr_d = 1'b1;
        end
      end
    end
    crs_d = carr_d || (!full_dup && tx_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carr_q  <= 1'b0;
      zcnt_q  <= '0;
      last0_q <= 1'b0;
      crs_q   <= 1'b0;
    end else begin
      carr_q  <= carr_d;
      zcnt_q  <= zcnt_d;
      last0_q <= last0_d;
      crs_q   <= crs_d;
    end
  end

  assign crs = crs_q;

endmodule

// File: rtl/mii_crs_col_gen.sv
module mii_crs_col_gen #(
  parameter int unsigned COL_DELAY_BITS = 7,
  parameter int unsigned HB_GAP_BITS    = 10,
  parameter int unsigned HB_LEN_BITS    = 10,
  parameter int unsigned ZEROS_NEEDED   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic rx_act,
  input  logic rx_valid,
  input  logic link_ok,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic bit_en,
  input  logic spd_100,
  input  logic full_dup,
  input  logic hb_en,
  input  logic eop,
  output logic crs,
  output logic col
);

  logic coll_col;
  logic hb_pulse;

  mii_coll_detect #(
    .DELAY_BITS (COL_DELAY_BITS)
  ) u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_act   (tx_act),
    .rx_act   (rx_act),
    .full_dup (full_dup),
    .spd_100  (spd_100),
    .bit_en   (bit_en),
    .coll_col (coll_col)
  );

  mii_sqe_timer #(
    .GAP_BITS (HB_GAP_BITS),
    .LEN_BITS (HB_LEN_BITS)
  ) u_sqe (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_act   (tx_act),
    .full_dup (full_dup),
    .spd_100  (spd_100),
    .hb_en    (hb_en),
    .bit_en   (bit_en),
    .hb_pulse (hb_pulse)
  );

  mii_crs_qual #(
    .ZEROS_NEEDED (ZEROS_NEEDED)
  ) u_crs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_act   (rx_act),
    .rx_valid (rx_valid),
    .link_ok  (link_ok),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .spd_100  (spd_100),
    .full_dup (full_dup),
    .tx_act   (tx_act),
    .eop      (eop),
    .crs      (crs)
  );

  assign col = coll_col || hb_pulse;

endmodule

// File: rtl/mii_crs_col_gen_chk.sv
module mii_crs_col_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_act,
  input logic rx_act,
  input logic spd_100,
  input logic full_dup,
  input logic eop,
  input logic coll_col,
  input logic hb_pulse,
  input logic crs,
  input logic col
);

  AST_FDX_COL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    full_dup |=> !col); // R10

  AST_FAST_COL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_100 && !full_dup && tx_act && rx_act) |=> coll_col); // R1

  AST_RX_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (!spd_100 && !full_dup && tx_act && rx_act && $past(rx_act) && !$past(tx_act)) |=> coll_col); // R3

  AST_COL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_act && rx_act) |=> !coll_col); // R4

  AST_HDX_TX_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup && tx_act) |=> crs); // R8

  AST_EOP_CRS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && (full_dup || !tx_act)) |=> !crs); // R9

  AST_NO_FAST_SQE: assert property (@(posedge clk) disable iff (!rst_n)
    spd_100 |=> !hb_pulse); // R5

endmodule

bind mii_crs_col_gen mii_crs_col_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_act   (tx_act),
  .rx_act   (rx_act),
  .spd_100  (spd_100),
  .full_dup (full_dup),
  .eop      (eop),
  .coll_col (coll_col),
  .hb_pulse (hb_pulse),
  .crs      (crs),
  .col      (col)
);

// File: tb/mii_crs_col_gen_test.sv
`timescale 1ns/1ps
module mii_crs_col_gen_test;

  logic clk;
  logic rst_n;
  logic tx_act, rx_act, rx_valid, link_ok, bit_stb, bit_val, bit_en;
  logic spd_100, full_dup, hb_en, eop;
  logic crs, col;

  int   n_chk;
  int   n_err;
  bit   done;
  bit   rnd_ben;
  int   ben_div;

  mii_crs_col_gen uut (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
    .rx_valid(rx_valid), .link_ok(link_ok), .bit_stb(bit_stb),
    .bit_val(bit_val), .bit_en(bit_en), .spd_100(spd_100),
    .full_dup(full_dup), .hb_en(hb_en), .eop(eop), .crs(crs), .col(col)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bit-time enable generator: every 4th cycle, or random
  int ben_cnt;
  initial begin
    bit_en  = 1'b0;
    ben_cnt = 0;
    forever begin
      @(negedge clk);
      if (rnd_ben) begin
        bit_en = (($urandom % 3) == 0);
      end else begin
        ben_cnt = (ben_cnt + 1) % ben_div;
        bit_en  = (ben_cnt == 0);
      end
    end
  end

  // cycle model built from the requirements
  bit m_collprev, m_rxprev, m_slow, m_colc, m_txprev, m_hbp;
  int m_cnt, m_hbst, m_hbcnt;
  bit m_seen0, m_last0, m_rxc, m_crs;
  bit m_rst_cyc;
  string col_tag, crs_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_collprev = 0; m_rxprev = 0; m_slow = 0; m_colc = 0; m_txprev = 0;
      m_hbp = 0; m_cnt = 0; m_hbst = 0; m_hbcnt = 0;
      m_seen0 = 0; m_last0 = 0; m_rxc = 0; m_crs = 0;
      m_rst_cyc = 1;
      col_tag = "R11"; crs_tag = "R11";
    end else begin
      bit coll, ok;
      m_rst_cyc = 0;
      coll = !full_dup && tx_act && rx_act;
      if (coll && !m_collprev) m_slow = !spd_100 && !m_rxprev;
      if (!coll) m_cnt = 0;
      else if (bit_en && m_cnt < 7) m_cnt = m_cnt + 1;
      m_colc = coll && (!m_slow || m_cnt == 7);
      ok = hb_en && !spd_100 && !full_dup;
      case (m_hbst)
        0: if (m_txprev && !tx_act && ok) begin m_hbst = 1; m_hbcnt = 0; end
        1: if (!ok || tx_act) m_hbst = 0;
           else if (bit_en) begin
             if (m_hbcnt == 9) begin m_hbst = 2; m_hbcnt = 0; end
             else m_hbcnt = m_hbcnt + 1;
           end
        default: if (!ok || tx_act) m_hbst = 0;
           else if (bit_en) begin
             if (m_hbcnt == 9) begin m_hbst = 0; m_hbcnt = 0; end
             else m_hbcnt = m_hbcnt + 1;
           end
      endcase
      m_hbp = (m_hbst == 2);
      if (eop || (spd_100 && !link_ok)) begin
        m_rxc = 0; m_seen0 = 0; m_last0 = 0;
        crs_tag = "R9";
      end else if (!spd_100) begin
        m_seen0 = 0; m_last0 = 0;
        if (rx_act && rx_valid) m_rxc = 1;
        crs_tag = "R6";
      end else begin
        if (bit_stb) begin
          if (!bit_val) begin
            if (!m_last0) begin
              if (m_seen0) m_rxc = 1;
              m_seen0 = 1;
            end
            m_last0 = 1;
          end else m_last0 = 0;
        end
        crs_tag = "R7";
      end
      m_crs = m_rxc || (!full_dup && tx_act);
      if (!full_dup && tx_act) crs_tag = "R8";
      if (full_dup) col_tag = "R10";
      else if (m_hbp) col_tag = "R5";
      else if (coll) col_tag = m_slow ? "R2" : (spd_100 ? "R1" : "R3");
      else col_tag = "R4";
      m_collprev = coll; m_rxprev = rx_act; m_txprev = tx_act;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_rst_cyc ? "R11" : col_tag, col, m_colc || m_hbp, "col");
      chk(m_rst_cyc ? "R11" : crs_tag, crs, m_crs, "crs");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_in();
    tx_act = 0; rx_act = 0; rx_valid = 0; bit_stb = 0; bit_val = 1; eop = 0;
  endtask

  task automatic send_bit(input logic v);
    bit_stb = 1; bit_val = v; cyc(1); bit_stb = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_err = 0; done = 0; rnd_ben = 0; ben_div = 4;
    rst_n = 0; idle_in(); link_ok = 1; spd_100 = 0; full_dup = 0; hb_en = 0;
    cyc(3);
    chk("R11", col, 1'b0, "col in reset");
    chk("R11", crs, 1'b0, "crs in reset");
    tx_act = 1; rx_act = 1; rx_valid = 1;
    cyc(2);
    chk("R11", col, 1'b0, "col in reset with activity");
    chk("R11", crs, 1'b0, "crs in reset with activity");
    idle_in();
    rst_n = 1;
    cyc(4);

    // R2: transmit first at 10 Mb/s, then a short collision that breaks
    tx_act = 1; cyc(3);
    rx_act = 1; cyc(12);
    chk("R2", col, 1'b0, "col held off early");
    rx_act = 0; cyc(2);
    rx_act = 1; cyc(40);
    chk("R2", col, 1'b1, "col after seven bits");
    rx_act = 0; cyc(1);
    tx_act = 0; cyc(6);
    // R2: simultaneous start
    tx_act = 1; rx_act = 1; cyc(40);
    idle_in(); cyc(5);
    // R3: receive first
    rx_act = 1; rx_valid = 1; cyc(4);
    tx_act = 1; cyc(1);
    chk("R3", col, 1'b1, "col right after receive-first collision");
    cyc(8);
    idle_in(); eop = 1; cyc(1); eop = 0; cyc(3);
    chk("R9", crs, 1'b0, "crs after eop");
    // R5: heartbeat
    hb_en = 1;
    tx_act = 1; cyc(6); tx_act = 0; cyc(100);
    tx_act = 1; cyc(3); tx_act = 0; cyc(50);
    tx_act = 1; cyc(2); tx_act = 0; cyc(20);
    hb_en = 0; cyc(30);
    // R10: full duplex
    full_dup = 1; hb_en = 1;
    tx_act = 1; rx_act = 1; cyc(40);
    chk("R10", col, 1'b0, "col in full duplex");
    rx_act = 0; cyc(3);
    chk("R8", crs, 1'b0, "crs from tx in full duplex");
    tx_act = 0; cyc(60);
    full_dup = 0; hb_en = 0; cyc(3);
    // R7 / R1: 100 Mb/s
    spd_100 = 1; link_ok = 1; cyc(2);
    send_bit(1); send_bit(0); send_bit(0); send_bit(1); send_bit(1);
    cyc(1);
    chk("R7", crs, 1'b0, "crs after adjacent zeros only");
    send_bit(0); cyc(1);
    chk("R7", crs, 1'b1, "crs after two separated zeros");
    eop = 1; cyc(1); eop = 0; cyc(1);
    chk("R9", crs, 1'b0, "crs cleared by eop");
    send_bit(0); send_bit(1); link_ok = 0; cyc(1); link_ok = 1; send_bit(0); cyc(1);
    chk("R9", crs, 1'b0, "link loss clears zero count");
    tx_act = 1; rx_act = 1; cyc(1);
    chk("R1", col, 1'b1, "col at 100 Mb/s");
    idle_in(); cyc(3);

    // random traffic
    rnd_ben = 1;
    for (int seg = 0; seg < 24; seg++) begin
      spd_100  = $urandom % 2;
      full_dup = (($urandom % 4) == 0);
      hb_en    = (($urandom % 3) != 0);
      for (int c = 0; c < 250; c++) begin
        if (($urandom % 25) == 0) tx_act = ~tx_act;
        if (($urandom % 25) == 0) rx_act = ~rx_act;
        rx_valid = (($urandom % 4) == 0);
        link_ok  = (($urandom % 40) != 0);
        bit_stb  = $urandom % 2;
        bit_val  = $urandom % 2;
        eop      = (($urandom % 40) == 0);
        cyc(1);
      end
    end
    idle_in(); cyc(5);
    finish_run();
  end

endmodule